// File: doc/BRIEF.md
# Scan Chain Length Probe

This block is a test-access host engine that works out how long the instruction-register path of an unknown test-access target is. It drives the four host-side test pins (TCK, TMS, TDI and the active-low test reset) and samples TDO. It holds the target's test logic in reset, forces the state machine to Test-Logic-Reset, and walks it into Shift-IR. It then flushes the path with ones and injects an eight-bit marker. It counts shift cycles until that marker comes back out on TDO.

The bits that drain out first are the instruction-register values that were captured after reset. The block keeps them as a packed vector. Bit 0 of that vector is the first bit that left TDO. When the walk is over, the engine leaves Shift-IR through Exit1-IR and Update-IR and parks the target in Run-Test/Idle. It then pulses `done` and holds its results until the next `start`. The test reset touches only the target's test logic and is never used as a system reset.

TCK is made from the system clock. Each TCK phase lasts `DIV` system clocks. TMS and TDI change only when TCK falls, and TDO is sampled as TCK rises.

Top module: `jtag_chain_probe`

## Requirements
- R1: Out of reset, `tck` is 0, `trst_n` is 1, `tms` is 1, and `done`, `err`, `chain_len` and `capture` are all 0.
- R2: A `start` seen while idle drives `trst_n` low for exactly `TRST_TCK` (2) rising TCK edges. After `trst_n` is released, `tms` is 1 on exactly `RESET_TCK` (5) rising edges before the first rising edge with `tms` at 0.
- R3: After the reset walk, `tms` takes the values 0,1,1,0,0 on successive rising edges, so the target is in Shift-IR after exactly 10 rising edges with `trst_n` high.
- R4: TCK has a period of 2·`DIV` system clocks. `tms` and `tdi` change only in the system clock where `tck` falls.
- R5: In Shift-IR, `tdi` carries `MAX_LEN` ones. It then carries the marker 0x5A most-significant bit first, and ones after that.
- R6: `chain_len` equals the number of rising edges from the first marker bit entering to the first marker bit being sampled on `tdo`. This holds for any length from 1 to `MAX_LEN`, including a 50-bit chain made of three devices.
- R7: `capture[i]` holds the i-th bit that left `tdo` in Shift-IR, counting from 0, for every i below the chain length. Positions at or above the chain length read 1, which is the fill value.
- R8: If the marker has not been seen after `MAX_LEN`+8 marker-phase rising edges, `err` is set to 1 and `chain_len` is set to 0.
- R9: On success and on timeout alike, the exit drives `tms` 1,1,0 so the target ends in Run-Test/Idle. `tck` is then left low and `done` is high for exactly one system clock.
- R10: `chain_len`, `err` and `capture` hold their values after `done` until the next accepted `start`. An accepted `start` clears `err`.
- R11: A `start` pulse while a probe is running has no effect on the sequence or its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe; accepted only while idle |
| tdo | input | 1 | Test data from the target |
| tck | output | 1 | Test clock, a divided system clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| trst_n | output | 1 | Active-low test-logic reset to the target |
| done | output | 1 | One-clock pulse when a probe ends |
| err | output | 1 | Marker not seen within the limit |
| chain_len | output | LEN_W (9) | Measured chain length in bits |
| capture | output | MAX_LEN (256) | Post-reset bits that drained out, first bit at index 0 |

## Verification
The hardest case to reach from the ports is the boundary of the timeout. With a chain of exactly `MAX_LEN`, the marker arrives on the very rising edge where the timeout would fire. With one more bit, the timeout must win. To reach both, the bench attaches a behavioural target with a full test-state machine and an instruction path whose length is set per run. It runs lengths of 256 and 257, and also a TDO stuck at 0. These are mixed with random lengths and captured patterns and the directed three-device 50-bit case. For each run, the bench logs TMS and TDI at every rising TCK edge, so the reset walk, the fill and the marker order are compared bit by bit.

// File: rtl/jcp_pkg.sv
package jcp_pkg;

  // Engine phases; each non-idle phase counts rising TCK strobes.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TRST = 3'd1,
    ST_TLR  = 3'd2,
    ST_NAV  = 3'd3,
    ST_FILL = 3'd4,
    ST_MARK = 3'd5,
    ST_EXIT = 3'd6,
    ST_DONE = 3'd7
  } probe_st_e;

  // TMS walk from Test-Logic-Reset to Shift-IR, bit k used on step k.
  localparam logic [4:0] NAV_TMS = 5'b00110;

endpackage

// File: rtl/jcp_tck_gen.sv
module jcp_tck_gen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tck,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          tck_q, tck_d;
  logic          wrap;

  assign wrap     = run && (div_q == DIV_LAST);
  assign rise_stb = wrap && !tck_q;
  assign fall_stb = wrap && tck_q;
  assign tck      = tck_q;

  always_comb begin
    div_d = div_q;
    tck_d = tck_q;
    if (!run) begin
      div_d = '0;
      tck_d = 1'b0;
    end else if (wrap) begin
      div_d = '0;
      tck_d = ~tck_q;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tck_q <= 1'b0;
    end else begin
      div_q <= div_d;
      tck_q <= tck_d;
    end
  end

endmodule

// File: rtl/jcp_marker_win.sv
module jcp_marker_win #(
  parameter int unsigned       MARK_W = 8,
  parameter logic [MARK_W-1:0] MARKER = 8'h5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift,
  input  logic bit_in,
  output logic hit
);

  logic [MARK_W-1:0] win_q, win_d, win_n;

  // Newest TDO bit enters at the LSB, so a marker sent MSB first lines up.
  assign win_n = {win_q[MARK_W-2:0], bit_in};
  assign hit   = shift && (win_n == MARKER);

  always_comb begin
    win_d = win_q;
    if (clr)        win_d = '1;
    else if (shift) win_d = win_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '1;
    else        win_q <= win_d;
  end

endmodule

// File: rtl/jcp_capture.sv
module jcp_capture #(
  parameter int unsigned DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             bit_in,
  output logic [DEPTH-1:0] cap
);

  logic [DEPTH-1:0] cap_q, cap_d;

  // Right shift: after DEPTH shifts the first bit in sits at index 0.
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    if (i == DEPTH - 1) begin : g_top
      assign cap_d[i] = shift ? bit_in : cap_q[i];
    end else begin : g_mid
      assign cap_d[i] = shift ? cap_q[i+1] : cap_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign cap = cap_q;

endmodule

// File: rtl/jtag_chain_probe.sv
module jtag_chain_probe
  import jcp_pkg::*;
#(
  parameter int unsigned       DIV       = 2,
  parameter int unsigned       MAX_LEN   = 256,
  parameter int unsigned       MARK_W    = 8,
  parameter logic [MARK_W-1:0] MARKER    = 8'h5A,
  parameter int unsigned       TRST_TCK  = 2,
  parameter int unsigned       RESET_TCK = 5,
  localparam int unsigned      LEN_W     = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               tdo,
  output logic               tck,
  output logic               tms,
  output logic               tdi,
  output logic               trst_n,
  output logic               done,
  output logic               err,
  output logic [LEN_W-1:0]   chain_len,
  output logic [MAX_LEN-1:0] capture
);

  localparam int unsigned     CNT_W      = $clog2(MAX_LEN + MARK_W + 1);
  localparam logic [CNT_W-1:0] TRST_LAST = CNT_W'(TRST_TCK - 1);
  localparam logic [CNT_W-1:0] TLR_LAST  = CNT_W'(RESET_TCK - 1);
  localparam logic [CNT_W-1:0] NAV_LAST  = CNT_W'(4);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(MAX_LEN - 1);
  localparam logic [CNT_W-1:0] TMO_CNT   = CNT_W'(MAX_LEN + MARK_W - 1);
  localparam logic [CNT_W-1:0] MK_OFS    = CNT_W'(MARK_W - 1);
  localparam logic [CNT_W-1:0] MK_CNT    = CNT_W'(MARK_W);
  localparam logic [CNT_W-1:0] EXIT_END  = CNT_W'(3);
  localparam logic [MARK_W-1:0] MK_TOP   = MARK_W'(1) << (MARK_W - 1);

  probe_st_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] lenw_q, lenw_d, len_q, len_d;
  logic             tmo_q, tmo_d, err_q, err_d;
  logic [2:0]       drv_q, drv_d, drv_v;   // {trst_n, tms, tdi}
  logic             run, rise_stb, fall_stb, hit, accept;
  logic             win_clr, win_shift, cap_shift, nav_bit, mk_bit;

  assign accept    = (state_q == ST_IDLE) && start;
  assign run       = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign win_clr   = (state_q != ST_MARK);
  assign win_shift = rise_stb && (state_q == ST_MARK);
  assign cap_shift = rise_stb && (state_q == ST_FILL);

  jcp_tck_gen #(.DIV(DIV)) u_tck (
    .clk(clk), .rst_n(rst_n), .run(run),
    .tck(tck), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  jcp_marker_win #(.MARK_W(MARK_W), .MARKER(MARKER)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .shift(win_shift),
    .bit_in(tdo), .hit(hit)
  );

  jcp_capture #(.DEPTH(MAX_LEN)) u_cap (
    .clk(clk), .rst_n(rst_n), .shift(cap_shift), .bit_in(tdo), .cap(capture)
  );

  // Phase sequencing, advanced on rising TCK strobes.
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lenw_d  = lenw_q;
    tmo_d   = tmo_q;
    unique case (state_q)
      ST_IDLE: if (start) begin state_d = ST_TRST; cnt_d = '0; end
      ST_TRST: if (rise_stb) begin
        if (cnt_q == TRST_LAST) begin state_d = ST_TLR; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      ST_TLR: if (rise_stb) begin
        if (cnt_q == TLR_LAST) begin state_d = ST_NAV; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      ST_NAV: if (rise_stb) begin
        if (cnt_q == NAV_LAST) begin state_d = ST_FILL; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      ST_FILL: if (rise_stb) begin
        if (cnt_q == FILL_LAST) begin state_d = ST_MARK; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      ST_MARK: if (rise_stb) begin
        if (hit) begin
          state_d = ST_EXIT; cnt_d = '0; tmo_d = 1'b0;
          lenw_d  = LEN_W'(cnt_q - MK_OFS);
        end else if (cnt_q == TMO_CNT) begin
          state_d = ST_EXIT; cnt_d = '0; tmo_d = 1'b1; lenw_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_EXIT: begin
        if (rise_stb) cnt_d = cnt_q + 1'b1;
        else if (fall_stb && (cnt_q == EXIT_END)) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Pin values applied at the next falling TCK strobe.
  always_comb begin
    nav_bit = |(NAV_TMS & (5'b00001 << cnt_q[2:0]));
    mk_bit  = |(MARKER & (MK_TOP >> cnt_q));
    unique case (state_q)
      ST_TRST: drv_v = 3'b011;
      ST_TLR:  drv_v = 3'b111;
      ST_NAV:  drv_v = {1'b1, nav_bit, 1'b1};
      ST_MARK: drv_v = {2'b10, (cnt_q < MK_CNT) ? mk_bit : 1'b1};
      ST_EXIT: drv_v = {1'b1, (cnt_q < CNT_W'(2)), 1'b1};
      default: drv_v = 3'b101;
    endcase
  end

  always_comb begin
    drv_d = drv_q;
    if (accept)        drv_d = {1'b0, drv_q[1:0]};
    else if (fall_stb) drv_d = drv_v;
  end

  // Result registers: loaded on entry to DONE, error cleared on accept.
  always_comb begin
    len_d = len_q;
    err_d = err_q;
    if (accept) err_d = 1'b0;
    if ((state_q == ST_EXIT) && (state_d == ST_DONE)) begin
      len_d = lenw_q;
      err_d = tmo_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lenw_q  <= '0;
      tmo_q   <= 1'b0;
      drv_q   <= 3'b111;
      len_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lenw_q  <= lenw_d;
      tmo_q   <= tmo_d;
      drv_q   <= drv_d;
      len_q   <= len_d;
      err_q   <= err_d;
    end
  end

  assign trst_n    = drv_q[2];
  assign tms       = drv_q[1];
  assign tdi       = drv_q[0];
  assign done      = (state_q == ST_DONE);
  assign err       = err_q;
  assign chain_len = len_q;

endmodule

// File: rtl/jcp_checker.sv
module jcp_checker #(
  parameter int unsigned LEN_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             tck,
  input logic             tms,
  input logic             tdi,
  input logic             trst_n,
  input logic             done,
  input logic             err,
  input logic [LEN_W-1:0] chain_len
);

  assert_trst_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trst_n) |-> $past(start));

  assert_tms_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tms) |-> $fell(tck));

  assert_tdi_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tdi) |-> $fell(tck));

  assert_timeout_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (chain_len == '0));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_tck_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tck);

  assert_len_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chain_len) |-> done);

  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err) |-> (done || $past(start)));

endmodule

bind jtag_chain_probe jcp_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tck(tck), .tms(tms), .tdi(tdi),
  .trst_n(trst_n), .done(done), .err(err), .chain_len(chain_len)
);

// File: tb/jtag_chain_probe_tb_top.sv
module jtag_chain_probe_tb_top;

  localparam int DIV  = 2;
  localparam int MAXL = 256;
  localparam logic [7:0] MK = 8'h5A;

  typedef enum logic [3:0] {
    T_TLR, T_RTI, T_SDR, T_CDR, T_SHDR, T_E1DR, T_PDR, T_E2DR, T_UDR,
    T_SIR, T_CIR, T_SHIR, T_E1IR, T_PIR, T_E2IR, T_UIR
  } tap_e;

  logic clk = 1'b0;
  logic rst_n, start;
  logic tck, tms, tdi, trst_n, done, err;
  logic [8:0]      chain_len;
  logic [MAXL-1:0] capture;
  logic tdo_m, tdo_w;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  // behavioural target
  tap_e        tap;
  logic [511:0] ir, tpat;
  int           tl = 8;
  bit           stuck0 = 1'b0;

  // logs
  int trst_cyc, pre_ones, pre_shift, nshift, per_bad, edge_bad, last_rise;
  bit seen_zero, rise_valid;
  bit tdi_log [0:599];
  logic tms_p, tdi_p, tck_p;

  always #10 clk = ~clk;

  assign tdo_w = stuck0 ? 1'b0 : tdo_m;

  jtag_chain_probe dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tdo(tdo_w),
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n),
    .done(done), .err(err), .chain_len(chain_len), .capture(capture)
  );

  function automatic tap_e tap_next(tap_e s, logic m);
    case (s)
      T_TLR:  return m ? T_TLR  : T_RTI;
      T_RTI:  return m ? T_SDR  : T_RTI;
      T_SDR:  return m ? T_SIR  : T_CDR;
      T_CDR:  return m ? T_E1DR : T_SHDR;
      T_SHDR: return m ? T_E1DR : T_SHDR;
      T_E1DR: return m ? T_UDR  : T_PDR;
      T_PDR:  return m ? T_E2DR : T_PDR;
      T_E2DR: return m ? T_UDR  : T_SHDR;
      T_UDR:  return m ? T_SDR  : T_RTI;
      T_SIR:  return m ? T_TLR  : T_CIR;
      T_CIR:  return m ? T_E1IR : T_SHIR;
      T_SHIR: return m ? T_E1IR : T_SHIR;
      T_E1IR: return m ? T_UIR  : T_PIR;
      T_PIR:  return m ? T_E2IR : T_PIR;
      T_E2IR: return m ? T_UIR  : T_SHIR;
      default: return m ? T_SDR : T_RTI;
    endcase
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tap <= T_TLR;
    end else begin
      if (tap == T_CIR) ir <= tpat;
      if (tap == T_SHIR) begin
        for (int i = 0; i < 511; i++) if (i < tl - 1) ir[i] <= ir[i+1];
        if (tl > 0) ir[tl-1] <= tdi;
      end
      tap <= tap_next(tap, tms);
    end
  end

  always @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo_m <= 1'b1;
    else         tdo_m <= (tap == T_SHIR) ? ir[0] : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(posedge tck) begin
    if (rise_valid && (cyc - last_rise) != 2 * DIV) per_bad++;
    rise_valid = 1'b1;
    last_rise  = cyc;
    if (!trst_n) begin
      trst_cyc++;
    end else begin
      if (!seen_zero) begin
        if (tms) pre_ones++;
        else     seen_zero = 1'b1;
      end
      if (tap == T_SHIR) begin
        if (nshift < 600) tdi_log[nshift] = tdi;
        nshift++;
      end else if (nshift == 0) begin
        pre_shift++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && (tms !== tms_p || tdi !== tdi_p) && !(tck == 1'b0 && tck_p == 1'b1))
      edge_bad++;
    tms_p = tms;
    tdi_p = tdi;
    tck_p = tck;
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_cap(int l, logic [511:0] p);
    logic [255:0] r;
    for (int i = 0; i < 256; i++) r[i] = (i < l) ? p[i] : 1'b1;
    return r;
  endfunction

  function automatic logic [511:0] rnd_pat();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic probe(input int len, input logic [511:0] pat, input bit stuck,
                       input bit poke, input bit exp_err);
    int w;
    int mk_cyc;
    bit fill_ok, mark_ok;
    tl = len; tpat = pat; stuck0 = stuck;
    trst_cyc = 0; pre_ones = 0; pre_shift = 0; nshift = 0;
    per_bad = 0; edge_bad = 0; seen_zero = 1'b0; rise_valid = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    w = 0;
    while (!done && w < 8000) begin
      @(negedge clk);
      w++;
      start = (poke && w == 300);
    end
    start = 1'b0;
    chk(done == 1'b1, "R9 done reached", 256'(done), 256'(1));
    rise_valid = 1'b0;
    chk(tck == 1'b0, "R9 tck low at done", 256'(tck), 256'(0));
    chk(err == exp_err, "R8 err flag", 256'(err), 256'(exp_err));
    if (!exp_err) begin
      chk(chain_len == 9'(len), "R6 chain length", 256'(chain_len), 256'(len));
      chk(capture == exp_cap(len, pat), "R7 capture image", capture, exp_cap(len, pat));
    end else begin
      chk(chain_len == 9'd0, "R8 length on timeout", 256'(chain_len), 256'(0));
    end
    chk(trst_cyc == 2, "R2 trst edges", 256'(trst_cyc), 256'(2));
    chk(pre_ones == 5, "R2 tms high edges", 256'(pre_ones), 256'(5));
    chk(pre_shift == 10, "R3 edges to Shift-IR", 256'(pre_shift), 256'(10));
    mk_cyc = exp_err ? (MAXL + 8) : (len + 8);
    chk(nshift == MAXL + mk_cyc + 1, "R5 shift edge count", 256'(nshift),
        256'(MAXL + mk_cyc + 1));
    fill_ok = 1'b1;
    for (int i = 0; i < MAXL; i++) if (tdi_log[i] !== 1'b1) fill_ok = 1'b0;
    chk(fill_ok, "R5 fill ones", 256'(fill_ok), 256'(1));
    mark_ok = 1'b1;
    for (int i = 0; i < 8; i++) if (tdi_log[MAXL+i] !== MK[7-i]) mark_ok = 1'b0;
    for (int i = MAXL + 8; i < MAXL + mk_cyc + 1 && i < 600; i++)
      if (tdi_log[i] !== 1'b1) mark_ok = 1'b0;
    chk(mark_ok, "R5 marker order", 256'(mark_ok), 256'(1));
    chk(per_bad == 0, "R4 tck period", 256'(per_bad), 256'(0));
    chk(edge_bad == 0, "R4 pins change on fall", 256'(edge_bad), 256'(0));
    @(negedge clk);
    chk(done == 1'b0, "R9 done one clock", 256'(done), 256'(0));
    chk(tap == T_RTI, "R9 target in Run-Test/Idle", 256'(tap), 256'(T_RTI));
  endtask

  initial begin
    logic [511:0] pat;
    logic [8:0]   hl;
    logic         he;
    logic [255:0] hc;
    int           seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; start = 1'b0;
    repeat (5) @(negedge clk);
    chk(tck == 1'b0 && trst_n == 1'b1 && tms == 1'b1, "R1 pins at reset",
        256'({tck, trst_n, tms}), 256'(3'b011));
    chk(done == 1'b0 && err == 1'b0 && chain_len == 9'd0 && capture == '0,
        "R1 results at reset", 256'({done, err, chain_len}), 256'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: three devices, 4 + 38 + 8 = 50 bits
    pat = '1;
    pat[3:0]   = 4'b0001;
    pat[41:4]  = 38'h15_5555_5551;
    pat[49:42] = 8'h81;
    probe(50, pat, 1'b0, 1'b0, 1'b0);

    probe(1, rnd_pat(), 1'b0, 1'b0, 1'b0);     // R6 shortest
    probe(MAXL, rnd_pat(), 1'b0, 1'b0, 1'b0);  // R6 longest, marker on limit edge
    probe(MAXL + 1, rnd_pat(), 1'b0, 1'b0, 1'b1); // R8 one bit too long

    // R10: err cleared by the next probe
    for (int k = 0; k < 6; k++) begin
      probe(2 + int'($urandom % 254), rnd_pat(), 1'b0, (k == 2), 1'b0); // R11 poke on k==2
    end

    probe(40, rnd_pat(), 1'b1, 1'b0, 1'b1);    // R8 TDO stuck low

    // R10: results held after done
    probe(77, rnd_pat(), 1'b0, 1'b0, 1'b0);
    hl = chain_len; he = err; hc = capture;
    repeat (40) @(negedge clk);
    chk(chain_len == hl && err == he && capture == hc, "R10 results held",
        256'(chain_len), 256'(hl));

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule